// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This unit collects five interrupt lines for a small processor core and tells the core which one to service next. The five lines are one non-maskable trap, three restart lines with fixed targets, and one general-purpose line. Each line uses its own sensing rule. The trap needs a rising edge and the level still held. One restart line is edge sensed and keeps the event in a latch. The other two restarts and the general line are level sensed.

The unit ranks the live requests by a fixed priority. It shows the winner as a `pending` flag and a 16-bit vector address. The general line has no vector. When the core accepts it, the unit raises a one-cycle acknowledge request, and the core holds its program counter during that cycle.

Software controls the unit in two ways. It writes a three-bit mask for the restart lines, and it issues commands that turn the global enable on or off. The core pulses `accept` at an instruction boundary to take the shown request. Accepting any interrupt turns the global enable off.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, `pending` is 0, `vector` is 0x0000 and `ack_req` is 0. The global enable is off. All three restart lines are masked, so a high 6.5 line stays ignored even after the enable is turned on.
- R2: Priority from highest to lowest is: trap, restart 7.5, restart 6.5, restart 5.5, general.
- R3: The vectors are fixed. Trap gives 0x0024, restart 7.5 gives 0x003C, restart 6.5 gives 0x0034 and restart 5.5 gives 0x002C. The general line, and the case with no request, give 0x0000.
- R4: A rising edge of `trap_in`, seen at a clock edge, sets the trap latch. The trap is requested only while that latch is set and `trap_in` is still high. The latch clears when `trap_in` is sampled low or when the trap is accepted. The trap ignores both the mask and the global enable.
- R5: A rising edge of `rst75_in` sets the 7.5 latch whatever the mask or enable. The latch holds after the pin falls, and only acceptance of restart 7.5 or reset clears it.
- R6: Restarts 6.5 and 5.5 follow their pin levels and keep no memory of them.
- R7: When `mask_we` is high, `mask_in` loads the mask. Bit 2 is 7.5, bit 1 is 6.5 and bit 0 is 5.5, and a 1 blocks that restart.
- R8: `ien_set` turns the global enable on and `ien_clr` turns it off, with `ien_clr` winning when both are high. With the enable off, the restarts and the general line are not requested.
- R9: `accept` while `pending` is high turns the global enable off. `accept` while `pending` is low changes nothing.
- R10: A general-line request shows `pending` with vector 0x0000. Accepting it drives `ack_req` high for exactly the cycle after `accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_in | input | 1 | Non-maskable trap line |
| rst75_in | input | 1 | Edge-sensed restart 7.5 line |
| rst65_in | input | 1 | Level-sensed restart 6.5 line |
| rst55_in | input | 1 | Level-sensed restart 5.5 line |
| gen_in | input | 1 | Level-sensed general interrupt line |
| mask_we | input | 1 | Load strobe for the restart mask |
| mask_in | input | 3 | New mask: bit2 = 7.5, bit1 = 6.5, bit0 = 5.5, 1 = masked |
| ien_set | input | 1 | Turn global enable on |
| ien_clr | input | 1 | Turn global enable off |
| accept | input | 1 | Core takes the shown request |
| pending | output | 1 | A request is live |
| vector | output | 16 | Target address of the winning request |
| ack_req | output | 1 | Acknowledge cycle for the general line |

## Verification
The hardest state to reach from the ports is a stored 7.5 event that is hidden behind something else. The event can be hidden by its mask, by the enable being off, or by a trap that outranks it. The stimulus pulses `rst75_in` while the line is masked, then unmasks it and checks that vector 0x003C appears with the pin already low. The priority scenario raises every line at once and accepts the winners one by one. Before each step it turns the enable back on, so each lower source in turn becomes visible, ending with the general line's acknowledge pulse.

// File: rtl/irq_prio_unit.sv
module irq_prio_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_in,
  input  logic        rst75_in,
  input  logic        rst65_in,
  input  logic        rst55_in,
  input  logic        gen_in,
  input  logic        mask_we,
  input  logic [2:0]  mask_in,
  input  logic        ien_set,
  input  logic        ien_clr,
  input  logic        accept,
  output logic        pending,
  output logic [15:0] vector,
  output logic        ack_req
);

  localparam logic [15:0] VEC_TRAP = 16'h0024;
  localparam logic [15:0] VEC_R75  = 16'h003C;
  localparam logic [15:0] VEC_R65  = 16'h0034;
  localparam logic [15:0] VEC_R55  = 16'h002C;

  logic       trap_prev, r75_prev;
  logic       trap_lat, r75_lat;
  logic [2:0] mask_q;
  logic       ien_q;
  logic       ack_q;
  logic [4:0] req, grant;

  wire trap_rise = trap_in & ~trap_prev;
  wire r75_rise  = rst75_in & ~r75_prev;

  assign req[4] = trap_lat & trap_in;
  assign req[3] = r75_lat  & ~mask_q[2] & ien_q;
  assign req[2] = rst65_in & ~mask_q[1] & ien_q;
  assign req[1] = rst55_in & ~mask_q[0] & ien_q;
  assign req[0] = gen_in & ien_q;

  always_comb begin
    grant = '0;
    if      (req[4]) grant[4] = 1'b1;
    else if (req[3]) grant[3] = 1'b1;
    else if (req[2]) grant[2] = 1'b1;
    else if (req[1]) grant[1] = 1'b1;
    else if (req[0]) grant[0] = 1'b1;
  end

  always_comb begin
    unique case (1'b1)
      grant[4]: vector = VEC_TRAP;
      grant[3]: vector = VEC_R75;
      grant[2]: vector = VEC_R65;
      grant[1]: vector = VEC_R55;
      default:  vector = 16'h0000;
    endcase
  end

  assign pending = |req;
  assign ack_req = ack_q;
  wire take = accept & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_prev <= 1'b1;
      r75_prev  <= 1'b1;
    end else begin
      trap_prev <= trap_in;
      r75_prev  <= rst75_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            trap_lat <= 1'b0;
    else if (trap_rise)                    trap_lat <= 1'b1;
    else if (!trap_in || (take && grant[4])) trap_lat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 r75_lat <= 1'b0;
    else if (r75_rise)          r75_lat <= 1'b1;
    else if (take && grant[3])  r75_lat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 3'b111;
    else if (mask_we) mask_q <= mask_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien_q <= 1'b0;
    else if (take)    ien_q <= 1'b0;
    else if (ien_clr) ien_q <= 1'b0;
    else if (ien_set) ien_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= take & grant[0];
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  vec_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vector != 16'h0000) |-> pending);

  // R4
  trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && grant[4]) |=> !trap_lat);

  // R5
  r75_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && grant[3] && !r75_rise) |=> !r75_lat);

  // R7
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[1] |-> !grant[2]);

  // R9
  ien_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ien_q);

  // R10
  ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(take));

endmodule

// File: tb/irq_prio_unit_test.sv
module irq_prio_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, gen_in = 0;
  logic mask_we = 0;
  logic [2:0] mask_in = 3'b111;
  logic ien_set = 0, ien_clr = 0, accept = 0;
  logic pending, ack_req;
  logic [15:0] vector;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_prio_unit uut (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rst75_in(rst75_in),
    .rst65_in(rst65_in), .rst55_in(rst55_in), .gen_in(gen_in),
    .mask_we(mask_we), .mask_in(mask_in), .ien_set(ien_set),
    .ien_clr(ien_clr), .accept(accept), .pending(pending),
    .vector(vector), .ack_req(ack_req));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    {trap_in, rst75_in, rst65_in, rst55_in, gen_in} = '0;
    {mask_we, ien_set, ien_clr, accept} = '0;
    rst_n = 1'b0; tick(); tick();
    rst_n = 1'b1; tick();
  endtask

  task automatic enable();
    ien_set = 1; tick(); ien_set = 0;
  endtask

  task automatic load_mask(logic [2:0] m);
    mask_in = m; mask_we = 1; tick(); mask_we = 0;
  endtask

  task automatic take();
    accept = 1; tick(); accept = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pending", {15'b0, pending}, 16'h0000);
    chk("R1 vector", vector, 16'h0000);
    chk("R1 ack", {15'b0, ack_req}, 16'h0000);
    enable();
    rst65_in = 1; tick();
    chk("R1 masked at reset", {15'b0, pending}, 16'h0000);
  endtask

  task automatic t_trap();
    do_reset();
    trap_in = 1; tick();
    chk("R4 trap pending w/o enable", {15'b0, pending}, 16'h0001);
    chk("R3 trap vector", vector, 16'h0024);
    take();
    chk("R4 trap cleared by accept", {15'b0, pending}, 16'h0000);
    trap_in = 0; tick();
    trap_in = 1; tick();
    trap_in = 0; #1;
    chk("R4 trap needs level", {15'b0, pending}, 16'h0000);
    tick();
  endtask

  task automatic t_r75();
    do_reset();
    enable(); load_mask(3'b000);
    rst75_in = 1; tick(); rst75_in = 0; tick();
    chk("R5 latch holds", {15'b0, pending}, 16'h0001);
    chk("R3 r75 vector", vector, 16'h003C);
    take();
    chk("R9 enable off after accept", {15'b0, pending}, 16'h0000);
    enable();
    chk("R5 latch cleared by accept", {15'b0, pending}, 16'h0000);
    load_mask(3'b100);
    rst75_in = 1; tick(); rst75_in = 0; tick();
    chk("R7 r75 masked", {15'b0, pending}, 16'h0000);
    load_mask(3'b000);
    chk("R5 latched while masked", vector, 16'h003C);
  endtask

  task automatic t_level();
    do_reset();
    enable(); load_mask(3'b000);
    rst65_in = 1; tick();
    chk("R6 r65 level", vector, 16'h0034);
    rst65_in = 0; tick();
    chk("R6 r65 dropped", {15'b0, pending}, 16'h0000);
    load_mask(3'b010);
    rst65_in = 1; rst55_in = 1; tick();
    chk("R7 r65 masked r55 wins", vector, 16'h002C);
  endtask

  task automatic t_priority();
    do_reset();
    enable(); load_mask(3'b000);
    {rst65_in, rst55_in, gen_in, rst75_in, trap_in} = 5'b11111; tick();
    rst75_in = 0; tick();
    chk("R2 trap first", vector, 16'h0024);
    take();
    chk("R9 all maskable gated", {15'b0, pending}, 16'h0000);
    enable();
    chk("R2 r75 second", vector, 16'h003C);
    take(); enable();
    chk("R2 r65 third", vector, 16'h0034);
    rst65_in = 0; tick();
    chk("R2 r55 fourth", vector, 16'h002C);
    rst55_in = 0; tick();
    chk("R10 general pending", {15'b0, pending}, 16'h0001);
    chk("R10 general vector", vector, 16'h0000);
    take();
    chk("R10 ack raised", {15'b0, ack_req}, 16'h0001);
    chk("R9 general gated after accept", {15'b0, pending}, 16'h0000);
    tick();
    chk("R10 ack one cycle", {15'b0, ack_req}, 16'h0000);
    trap_in = 0; gen_in = 0; tick();
  endtask

  task automatic t_ien();
    do_reset();
    load_mask(3'b000);
    gen_in = 1; tick();
    chk("R8 enable off blocks", {15'b0, pending}, 16'h0000);
    enable();
    chk("R8 enable on", {15'b0, pending}, 16'h0001);
    ien_set = 1; ien_clr = 1; tick(); ien_set = 0; ien_clr = 0;
    chk("R8 clear wins", {15'b0, pending}, 16'h0000);
    gen_in = 0; enable();
    take();
    gen_in = 1; tick();
    chk("R9 idle accept no effect", {15'b0, pending}, 16'h0001);
    chk("R10 no ack idle", {15'b0, ack_req}, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_trap();
    t_r75();
    t_level();
    t_priority();
    t_ien();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule